// File: doc/BRIEF.md
# Serial EEPROM I2C Target

This block is a byte-addressable memory that behaves as a small serial EEPROM on an I2C bus. An I2C target front end handles bit timing and hands it byte-level events: a START (plain or repeated, on the same strobe), a STOP, a received byte, a request for the next byte to transmit, and the controller's ACK or NACK after each byte the block sent. The block returns an acknowledge decision for every byte it accepts and the data for every byte it is asked to send. Parameters set the array size, the page size, whether the word address takes one or two bytes, how many hardware select pins take part in the match, the fixed control code and the address counter's reset value.

One address counter is shared by all transactions. Writes stage bytes in a page buffer and commit them at STOP; while writing, the counter wraps inside its page. While reading, the counter runs on through the whole array and wraps at its end. The state machine has seven states: IDLE (waits for START), CTRL (takes the control byte), AHI (high address byte, two-byte mode only), ALO (low or only address byte), WDATA (stages write data), RDATA (streams read data) and IGNORE (deaf until START). Transitions: START from any state goes to CTRL; STOP from any state goes to IDLE; CTRL goes to IGNORE on a mismatch, to RDATA on a matching read, to AHI or ALO on a matching write; AHI goes to ALO; ALO goes to WDATA; RDATA goes to IGNORE on a controller NACK.

Top module: `eeprom_i2c_target`

## Requirements
- R1: After reset ack_valid and tx_valid are low and the address counter holds the INIT_ADDR parameter, so a current-address read as the first transaction returns the byte at INIT_ADDR.
- R2: A control byte matches when bits 7..4 equal the CTRL_CODE parameter (default 4'b1010) and, for each k below PIN_COUNT, bit 1+k equals pin_sel[k]; bit positions at or above PIN_COUNT are ignored. Bit 0 is 1 for read, 0 for write. A matching control byte is acknowledged (ack_valid and ack high) in the cycle after rx_valid.
- R3: A control byte that does not match gets ack_valid high with ack low, and until the next START no further byte is acknowledged, no byte is transmitted and memory is not changed.
- R4: After a write control byte the word address follows; with two address bytes the high byte comes first. Each address byte is acknowledged and the address counter is loaded with the low log2(MEM_BYTES) bits of the word address.
- R5: Write data bytes are acknowledged and staged; they reach memory only at STOP. A START before STOP discards them.
- R6: Each staged write byte advances the counter by one inside its page of PAGE_BYTES bytes; past the last byte of the page it wraps to the first byte of the same page, and later bytes overwrite earlier ones at the same place.
- R7: A read control byte straight after START returns the byte at the current counter value (current-address read).
- R8: In read mode each tx_req yields tx_valid with the byte at the counter one cycle later, and the counter advances by one, wrapping from the last array byte to address 0 (random and sequential reads).
- R9: A controller NACK during a read ends transmission: later tx_req pulses are ignored until START.
- R10: A write transaction with no data bytes after the word address changes no memory and only sets the counter.
- R11: Received bytes in read mode and tx_req outside read mode are ignored: no acknowledge, no transmission, no change of counter or memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_sel | input | 3 | Hardware select pins compared with the control byte |
| evt_start | input | 1 | START or repeated START seen on the bus |
| evt_stop | input | 1 | STOP seen on the bus |
| rx_valid | input | 1 | A byte from the controller is in rx_byte |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Front end asks for the next byte to send |
| host_ack_valid | input | 1 | Controller's acknowledge bit for the last sent byte is valid |
| host_nack | input | 1 | 1 when the controller answered NACK |
| ack_valid | output | 1 | Acknowledge decision for the previous received byte is valid |
| ack | output | 1 | 1 to acknowledge, 0 to not acknowledge |
| tx_valid | output | 1 | tx_byte holds the byte to send |
| tx_byte | output | 8 | Read data |

## Verification
The assertions watch every cycle that an acknowledge only follows a received byte, that transmit data only follows a request made in the read state, that a write step never leaves its page, that a read step adds exactly one to the counter, and that a commit returns the machine to idle. Whether the right bytes land at the right addresses, that staged data vanishes on a repeated START, that an address-only write just moves the pointer, that the array wraps on reads, and that a mismatch or a NACK silences the block can only be shown by the bench's transactions compared against its reference model.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_AHI,
        ST_ALO,
        ST_WDATA,
        ST_RDATA,
        ST_IGNORE
    } tgt_state_e;
endpackage

// File: rtl/eeprom_ctrl_decode.sv
module eeprom_ctrl_decode #(
    parameter int         PIN_COUNT = 3,
    parameter logic [3:0] CTRL_CODE = 4'b1010
) (
    input  logic [7:0] ctrl_byte,
    input  logic [2:0] pin_sel,
    output logic       hit,
    output logic       is_read
);
    logic [2:0] pin_mask;

    // Only the lowest PIN_COUNT select positions take part in the match.
    for (genvar g = 0; g < 3; g++) begin : g_mask
        assign pin_mask[g] = (g < PIN_COUNT);
    end

    always_comb begin
        hit     = (ctrl_byte[7:4] == CTRL_CODE)
                  && (((ctrl_byte[3:1] ^ pin_sel) & pin_mask) == 3'b000);
        is_read = ctrl_byte[0];
    end
endmodule

// File: rtl/eeprom_addr_ctr.sv
module eeprom_addr_ctr #(
    parameter int ADDR_W    = 8,
    parameter int PG_W      = 4,
    parameter int INIT_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_page,
    input  logic              inc_lin,
    output logic [ADDR_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= ADDR_W'(INIT_ADDR);
        end else if (load) begin
            cnt <= load_val;
        end else if (inc_page) begin
            // Write stepping keeps the page bits and wraps the offset.
            cnt <= {cnt[ADDR_W-1:PG_W], PG_W'(cnt[PG_W-1:0] + 1'b1)};
        end else if (inc_lin) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 16,
    parameter int ADDR_W     = 8,
    parameter int PG_W       = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stage_we,
    input  logic [PG_W-1:0]        stage_off,
    input  logic [7:0]             stage_byte,
    input  logic                   drop,
    input  logic                   commit,
    input  logic [ADDR_W-PG_W-1:0] page_sel,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [7:0]             rd_byte
);
    logic [7:0]            mem  [MEM_BYTES];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
            pvld <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (pvld[i]) mem[{page_sel, PG_W'(i)}] <= pbuf[i];
            end
            pvld <= '0;
        end else if (drop) begin
            pvld <= '0;
        end else if (stage_we) begin
            pvld[stage_off] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (stage_we) pbuf[stage_off] <= stage_byte;
    end

    assign rd_byte = mem[rd_addr];
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
    import eeprom_i2c_pkg::*;
#(
    parameter int         MEM_BYTES  = 256,
    parameter int         PAGE_BYTES = 16,
    parameter int         ADDR_BYTES = 1,
    parameter int         PIN_COUNT  = 3,
    parameter logic [3:0] CTRL_CODE  = 4'b1010,
    parameter int         INIT_ADDR  = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] pin_sel,
    input  logic       evt_start,
    input  logic       evt_stop,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    input  logic       host_ack_valid,
    input  logic       host_nack,
    output logic       ack_valid,
    output logic       ack,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int PG_W   = $clog2(PAGE_BYTES);

    tgt_state_e        state, state_nx;
    logic [7:0]        hi_q;
    logic              hit, is_read;
    logic              bus_quiet, rx_in;
    logic              ctr_load, inc_page, inc_lin, commit;
    logic [15:0]       word_addr;
    logic [ADDR_W-1:0] cnt;
    logic [7:0]        rd_byte;

    assign bus_quiet = !evt_start && !evt_stop;
    assign rx_in     = rx_valid && bus_quiet;
    assign ctr_load  = rx_in && (state == ST_ALO);
    assign inc_page  = rx_in && (state == ST_WDATA);
    assign inc_lin   = tx_req && bus_quiet && (state == ST_RDATA);
    assign commit    = evt_stop && (state == ST_WDATA);
    assign word_addr = (ADDR_BYTES == 2) ? {hi_q, rx_byte} : {8'h00, rx_byte};

    eeprom_ctrl_decode #(.PIN_COUNT(PIN_COUNT), .CTRL_CODE(CTRL_CODE)) u_dec (
        .ctrl_byte (rx_byte),
        .pin_sel   (pin_sel),
        .hit       (hit),
        .is_read   (is_read)
    );

    eeprom_addr_ctr #(.ADDR_W(ADDR_W), .PG_W(PG_W), .INIT_ADDR(INIT_ADDR)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (word_addr[ADDR_W-1:0]),
        .inc_page (inc_page),
        .inc_lin  (inc_lin),
        .cnt      (cnt)
    );

    eeprom_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
                   .ADDR_W(ADDR_W), .PG_W(PG_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage_we   (inc_page),
        .stage_off  (cnt[PG_W-1:0]),
        .stage_byte (rx_byte),
        .drop       (evt_start),
        .commit     (commit),
        .page_sel   (cnt[ADDR_W-1:PG_W]),
        .rd_addr    (cnt),
        .rd_byte    (rd_byte)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (evt_start) begin
            state_nx = ST_CTRL;
        end else if (evt_stop) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_CTRL: if (rx_valid) begin
                    if (!hit)         state_nx = ST_IGNORE;
                    else if (is_read) state_nx = ST_RDATA;
                    else              state_nx = (ADDR_BYTES == 2) ? ST_AHI : ST_ALO;
                end
                ST_AHI:   if (rx_valid) state_nx = ST_ALO;
                ST_ALO:   if (rx_valid) state_nx = ST_WDATA;
                ST_RDATA: if (host_ack_valid && host_nack) state_nx = ST_IGNORE;
                ST_IDLE, ST_WDATA, ST_IGNORE: state_nx = state;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            hi_q  <= 8'h00;
        end else begin
            state <= state_nx;
            if (rx_in && state == ST_AHI) hi_q <= rx_byte;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack       <= 1'b0;
            tx_valid  <= 1'b0;
            tx_byte   <= 8'h00;
        end else begin
            ack_valid <= 1'b0;
            ack       <= 1'b0;
            if (rx_in) begin
                unique case (state)
                    ST_CTRL: begin
                        ack_valid <= 1'b1;
                        ack       <= hit;
                    end
                    ST_AHI, ST_ALO, ST_WDATA: begin
                        ack_valid <= 1'b1;
                        ack       <= 1'b1;
                    end
                    ST_IDLE, ST_RDATA, ST_IGNORE: ack_valid <= 1'b0;
                    default: ack_valid <= 1'b0;
                endcase
            end
            tx_valid <= inc_lin;
            if (inc_lin) tx_byte <= rd_byte;
        end
    end
endmodule

// File: rtl/eeprom_i2c_target_chk.sv
module eeprom_i2c_target_chk
    import eeprom_i2c_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PG_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              tx_req,
    input logic              ack_valid,
    input logic              tx_valid,
    input tgt_state_e        state,
    input logic [ADDR_W-1:0] cnt,
    input logic              inc_page,
    input logic              inc_lin,
    input logic              commit
);
    // R2: an acknowledge decision answers a byte received one cycle before
    a_r2_ack_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(rx_valid));

    // R8: transmit data answers a request one cycle before
    a_r8_tx_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_req));

    // R11: bytes are only sent when the request met the read state
    a_r11_tx_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ($past(state) == ST_RDATA));

    // R6: a write step stays in its page
    a_r6_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        inc_page |=> (cnt[ADDR_W-1:PG_W] == $past(cnt[ADDR_W-1:PG_W])));

    // R8: a read step adds one, wrapping at the array end
    a_r8_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc_lin |=> (cnt == ADDR_W'($past(cnt) + 1'b1)));

    // R5: a commit closes the write transaction
    a_r5_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state == ST_IDLE));
endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk #(.ADDR_W(ADDR_W), .PG_W(PG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .tx_req    (tx_req),
    .ack_valid (ack_valid),
    .tx_valid  (tx_valid),
    .state     (state),
    .cnt       (cnt),
    .inc_page  (inc_page),
    .inc_lin   (inc_lin),
    .commit    (commit)
);

// File: tb/eeprom_i2c_target_tb.sv
module eeprom_i2c_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MEM        = 512;
    localparam int PG         = 16;
    localparam int INIT       = 5;
    localparam logic [7:0] CW = 8'hA2;  // code 1010, pins a1=0 a0=1, write
    localparam logic [7:0] CR = 8'hA3;  // same, read

    localparam int M_IDLE = 0, M_CTRL = 1, M_AHI = 2, M_ALO = 3,
                   M_WD = 4, M_RD = 5, M_IGN = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pin_sel = 3'b101;
    logic       evt_start = 0, evt_stop = 0, rx_valid = 0, tx_req = 0;
    logic       host_ack_valid = 0, host_nack = 0;
    logic [7:0] rx_byte = 8'h00;
    logic       ack_valid, ack, tx_valid;
    logic [7:0] tx_byte;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_i2c_target #(
        .MEM_BYTES(MEM), .PAGE_BYTES(PG), .ADDR_BYTES(2),
        .PIN_COUNT(2), .CTRL_CODE(4'b1010), .INIT_ADDR(INIT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_sel(pin_sel),
        .evt_start(evt_start), .evt_stop(evt_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
        .host_ack_valid(host_ack_valid), .host_nack(host_nack),
        .ack_valid(ack_valid), .ack(ack), .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    // Reference model state
    logic [7:0] mem_m [MEM];
    logic [7:0] pbuf_m [PG];
    bit         pvld_m [PG];
    int         cnt_m = INIT;
    int         md = M_IDLE;
    logic [7:0] hi_m = 8'h00;

    int    n_run = 0, n_fail = 0;
    string tag = "R1";
    logic  e_av = 0, e_ack = 0, e_tv = 0;
    logic [7:0] e_tb = 8'h00;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        n_run++;
        if (ack_valid !== e_av || (e_av && ack !== e_ack) ||
            tx_valid !== e_tv || (e_tv && tx_byte !== e_tb)) begin
            n_fail++;
            $display("FAIL %s: actual av=%0b ack=%0b tv=%0b tb=%02h expected av=%0b ack=%0b tv=%0b tb=%02h",
                     tag, ack_valid, ack, tx_valid, tx_byte, e_av, e_ack, e_tv, e_tb);
        end
        evt_start = 0; evt_stop = 0; rx_valid = 0; tx_req = 0;
        host_ack_valid = 0; host_nack = 0;
        e_av = 0; e_ack = 0; e_tv = 0;
    endtask

    task automatic ev_start();
        evt_start = 1;
        for (int i = 0; i < PG; i++) pvld_m[i] = 0;
        md = M_CTRL;
        tick();
    endtask

    task automatic ev_stop();
        evt_stop = 1;
        if (md == M_WD)
            for (int i = 0; i < PG; i++)
                if (pvld_m[i]) mem_m[(cnt_m / PG) * PG + i] = pbuf_m[i];
        md = M_IDLE;
        tick();
    endtask

    task automatic put(input logic [7:0] b);
        bit hit;
        rx_valid = 1; rx_byte = b;
        case (md)
            M_CTRL: begin
                hit = (b[7:4] == 4'hA) && (b[2:1] == pin_sel[1:0]);
                e_av = 1; e_ack = hit;
                md = !hit ? M_IGN : (b[0] ? M_RD : M_AHI);
            end
            M_AHI: begin e_av = 1; e_ack = 1; hi_m = b; md = M_ALO; end
            M_ALO: begin
                e_av = 1; e_ack = 1;
                cnt_m = ((int'(hi_m) << 8) | int'(b)) % MEM;
                md = M_WD;
            end
            M_WD: begin
                e_av = 1; e_ack = 1;
                pbuf_m[cnt_m % PG] = b; pvld_m[cnt_m % PG] = 1;
                cnt_m = (cnt_m / PG) * PG + ((cnt_m % PG) + 1) % PG;
            end
            default: ;
        endcase
        tick();
    endtask

    task automatic get();
        tx_req = 1;
        if (md == M_RD) begin
            e_tv = 1; e_tb = mem_m[cnt_m];
            cnt_m = (cnt_m + 1) % MEM;
        end
        tick();
    endtask

    task automatic host(input bit nack);
        host_ack_valid = 1; host_nack = nack;
        if (md == M_RD && nack) md = M_IGN;
        tick();
    endtask

    task automatic set_addr(input int a);
        put(CW); put(8'((a >> 8) & 8'hFF)); put(8'(a & 8'hFF));
    endtask

    task automatic write_seq(input int a, input logic [7:0] q[$]);
        ev_start(); set_addr(a);
        foreach (q[i]) put(q[i]);
        ev_stop();
    endtask

    task automatic rand_read(input int a, input int n);
        ev_start(); set_addr(a); ev_start(); put(CR);
        for (int i = 0; i < n; i++) begin get(); host(i == n - 1); end
        ev_stop();
    endtask

    task automatic cur_read(input int n);
        ev_start(); put(CR);
        for (int i = 0; i < n; i++) begin get(); host(i == n - 1); end
        ev_stop();
    endtask

    bit done = 0;

    initial begin
        for (int i = 0; i < MEM; i++) mem_m[i] = 8'h00;
        for (int i = 0; i < PG; i++) pvld_m[i] = 0;
        repeat (3) @(negedge clk);
        tag = "R1";
        tick(); tick();               // outputs low during reset
        rst_n = 1;
        tick(); tick();               // outputs low after reset
        cur_read(2);                  // R1 R7: reads INIT and INIT+1

        tag = "R5"; write_seq(16'h0123, '{8'h5A});
        tag = "R4"; rand_read(16'h0123, 3);

        tag = "R6"; write_seq(16'h013E, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55});
        rand_read(16'h0130, 2);
        rand_read(16'h013E, 2);
        tag = "R7"; rand_read(16'h0130, 2); cur_read(1);

        tag = "R5";                   // repeated START drops staged data
        ev_start(); set_addr(16'h0010); put(8'h77);
        ev_start(); put(CR); get(); host(1); ev_stop();
        rand_read(16'h0010, 1);

        tag = "R10";
        write_seq(16'h0040, '{8'h9C});
        rand_read(16'h01F0, 1);
        write_seq(16'h0040, '{});
        cur_read(1);

        tag = "R8";
        write_seq(16'h01FF, '{8'hE1});
        write_seq(16'h0000, '{8'hE2});
        rand_read(16'h01FF, 3);

        tag = "R2";                   // bit 3 is an ignored pin position
        ev_start(); put(8'hAB); get(); host(1); ev_stop();
        ev_start(); put(8'hAA); put(8'h00); put(8'h60); put(8'hD4); ev_stop();
        rand_read(16'h0060, 1);

        tag = "R3";
        ev_start(); put(8'hA0); put(8'h00); put(8'h70); put(8'h12); get(); ev_stop();
        ev_start(); put(8'hB2); put(8'h00); put(8'h71); put(8'h34); ev_stop();
        cur_read(1);
        rand_read(16'h0070, 2);

        tag = "R9";
        rand_read(16'h0060, 1);
        ev_start(); put(CR); get(); host(1); get(); get(); ev_stop();

        tag = "R11";
        ev_start(); put(CR); put(8'h33); get(); host(1); ev_stop();
        ev_start(); set_addr(16'h0020); get(); put(8'h66); get(); ev_stop();
        rand_read(16'h0020, 2);
        tick(); tick();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual run did not end, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule